// File: doc/BRIEF.md
# Canceling Delay-Slot Branch Controller

This block steers instruction fetch for a five-stage pipeline whose branches have exactly one delay slot, and it decides whether the delay-slot instruction may commit. Every branch carries a direction chosen ahead of time. The instruction that follows a branch is always fetched. When the branch resolves in the decode stage, the controller compares the real outcome with the chosen direction. If they agree, the slot instruction runs normally. If they disagree, the slot is cancelled: its register-file and memory write enables are forced low while it is in decode, so it moves on as a harmless no-op.

A branch that carries no explicit hint gets a direction from the sign of its offset. A backward branch (negative offset) is treated as taken, and a forward branch as not taken. After the slot, fetch goes to the branch target if the branch was taken and falls through otherwise, whatever the prediction was. A branch that sits in a delay slot is an illegal sequence. It is reported on an error output and has no effect on fetch. Two wrapping counters record resolved branches and cancelled slots, so the misprediction rate can be read during simulation.

The slot tracker is a three-state machine:
- `S_IDLE`: no slot is pending.
- `S_KEEP`: the slot instruction is in decode and commits.
- `S_KILL`: the slot instruction is in decode and is cancelled.

Its transitions are:
- Idle-to-keep: a legal branch resolves as predicted.
- Idle-to-kill: a legal branch resolves against its prediction.
- Slot-to-idle: taken from either slot state on the following cycle, whether or not an illegal branch is present.
- Idle-to-idle: no branch is present.

Top module: `cancel_slot_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `fetch_pc` equals `RESET_PC`, `slot_nullify` and `seq_err` are 0, and both counters are 0.
- R2: In a cycle with no legal branch, `next_pc` is `fetch_pc + 4`, and `fetch_pc` takes that value at the next clock edge.
- R3: The effective prediction is `hint_taken` when `hint_valid` is 1. Otherwise it is `off_neg`, where 1 means backward and therefore taken.
- R4: If a legal branch resolves with `br_taken` equal to the prediction, then in the next cycle `slot_nullify` is 0 and `rf_we`/`mem_we` equal `dec_rf_we`/`dec_mem_we`.
- R5: If a legal branch resolves with `br_taken` different from the prediction, then in the next cycle `slot_nullify` is 1 and `rf_we` and `mem_we` are 0.
- R6: In the cycle a legal branch resolves, `next_pc` is `br_target` if `br_taken` is 1, and `fetch_pc + 4` otherwise. The prediction has no influence, and `fetch_pc` takes `next_pc` at the next edge.
- R7: `slot_nullify` is never 1 in two consecutive cycles.
- R8: A branch (`br_valid`=1) in the cycle right after a legal branch is illegal. In that cycle `seq_err` is 1 and `next_pc` is `fetch_pc + 4`. In the next cycle `slot_nullify` is 0 and `branch_cnt` is unchanged. `seq_err` is 0 in every other cycle.
- R9: `branch_cnt` rises by one, modulo 2^CW, in the cycle after each legal branch.
- R10: `squash_cnt` rises by one, modulo 2^CW, in the same cycle that `slot_nullify` is 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | The instruction in decode is a resolving branch |
| hint_valid | input | 1 | The branch carries an explicit direction hint |
| hint_taken | input | 1 | Hinted direction, 1 = taken |
| off_neg | input | 1 | Sign of the branch offset, 1 = backward |
| br_taken | input | 1 | Resolved outcome, 1 = taken |
| br_target | input | AW | Branch target address |
| dec_rf_we | input | 1 | Register write enable of the instruction in decode |
| dec_mem_we | input | 1 | Memory write enable of the instruction in decode |
| fetch_pc | output | AW | Address being fetched this cycle |
| next_pc | output | AW | Address to fetch next cycle |
| slot_nullify | output | 1 | The instruction in decode is a cancelled slot |
| rf_we | output | 1 | Register write enable after cancellation |
| mem_we | output | 1 | Memory write enable after cancellation |
| seq_err | output | 1 | Branch found in a delay slot |
| branch_cnt | output | CW | Count of legal resolved branches |
| squash_cnt | output | CW | Count of cancelled slots |

## Verification
Three results appear in the same cycle as the stimulus, because they are combinational:
- `next_pc`
- `seq_err`
- the gated enables, relative to the current slot state

Four results appear one clock edge after the branch:
- `fetch_pc`
- `slot_nullify`
- `branch_cnt`
- `squash_cnt`

The bench changes inputs right after a falling edge and compares every output a quarter period later, before the next rising edge. Its model holds the pending-slot state, PC and counts from earlier edges, so same-cycle results are checked against the present inputs and one-edge results against the model updated on the previous cycle.

// File: rtl/csc_pkg.sv
package csc_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_KEEP = 2'd1,
        S_KILL = 2'd2
    } slot_state_e;

endpackage

// File: rtl/csc_dir_pred.sv
module csc_dir_pred (
    input  logic hint_valid,
    input  logic hint_taken,
    input  logic off_neg,
    input  logic br_taken,
    output logic pred_taken,
    output logic mispredict
);
    // explicit hint wins; otherwise backward (negative offset) is taken
    always_comb begin
        pred_taken = hint_valid ? hint_taken : off_neg;
        mispredict = pred_taken ^ br_taken;
    end
endmodule

// File: rtl/csc_slot_fsm.sv
module csc_slot_fsm
    import csc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic br_valid,
    input  logic mispredict,
    output logic resolve,
    output logic seq_err,
    output logic slot_nullify,
    output logic kill_enter
);
    slot_state_e state_q, state_d;
    logic        in_slot;

    always_comb begin
        in_slot = (state_q != S_IDLE);
    end

    always_comb begin
        state_d = S_IDLE;
        unique case (state_q)
            S_IDLE: begin
                if (br_valid) state_d = mispredict ? S_KILL : S_KEEP;
                else          state_d = S_IDLE;
            end
            S_KEEP:  state_d = S_IDLE;
            S_KILL:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        resolve      = br_valid && !in_slot;
        seq_err      = br_valid && in_slot;
        slot_nullify = (state_q == S_KILL);
        kill_enter   = (state_d == S_KILL);
    end
endmodule

// File: rtl/csc_pc_unit.sv
module csc_pc_unit #(
    parameter int            AW         = 32,
    parameter int            INSN_BYTES = 4,
    parameter logic [AW-1:0] RESET_PC   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          redirect,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] next_pc
);
    localparam logic [AW-1:0] PC_STEP = AW'(INSN_BYTES);

    logic [AW-1:0] pc_q;

    always_comb begin
        next_pc  = redirect ? target : (pc_q + PC_STEP);
        fetch_pc = pc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= next_pc;
    end
endmodule

// File: rtl/csc_event_cnt.sv
module csc_event_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (bump) count <= count + ONE;
    end
endmodule

// File: rtl/cancel_slot_ctrl.sv
module cancel_slot_ctrl #(
    parameter int            AW       = 32,
    parameter int            CW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic          hint_valid,
    input  logic          hint_taken,
    input  logic          off_neg,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic          dec_rf_we,
    input  logic          dec_mem_we,
    output logic [AW-1:0] fetch_pc,
    output logic [AW-1:0] next_pc,
    output logic          slot_nullify,
    output logic          rf_we,
    output logic          mem_we,
    output logic          seq_err,
    output logic [CW-1:0] branch_cnt,
    output logic [CW-1:0] squash_cnt
);
    logic pred_taken;
    logic mispredict;
    logic resolve;
    logic kill_enter;
    logic redirect;

    csc_dir_pred u_pred (
        .hint_valid (hint_valid),
        .hint_taken (hint_taken),
        .off_neg    (off_neg),
        .br_taken   (br_taken),
        .pred_taken (pred_taken),
        .mispredict (mispredict)
    );

    csc_slot_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .br_valid     (br_valid),
        .mispredict   (mispredict),
        .resolve      (resolve),
        .seq_err      (seq_err),
        .slot_nullify (slot_nullify),
        .kill_enter   (kill_enter)
    );

    // only a legal, taken branch steers fetch; the prediction never does
    always_comb begin
        redirect = resolve && br_taken;
        rf_we    = dec_rf_we  && !slot_nullify;
        mem_we   = dec_mem_we && !slot_nullify;
    end

    csc_pc_unit #(
        .AW         (AW),
        .INSN_BYTES (4),
        .RESET_PC   (RESET_PC)
    ) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .redirect (redirect),
        .target   (br_target),
        .fetch_pc (fetch_pc),
        .next_pc  (next_pc)
    );

    csc_event_cnt #(.W(CW)) u_br_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (resolve),
        .count (branch_cnt)
    );

    csc_event_cnt #(.W(CW)) u_sq_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (kill_enter),
        .count (squash_cnt)
    );
endmodule

// File: rtl/cancel_slot_ctrl_chk.sv
module cancel_slot_ctrl_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          br_valid,
    input logic          hint_valid,
    input logic          hint_taken,
    input logic          off_neg,
    input logic          br_taken,
    input logic [AW-1:0] br_target,
    input logic [AW-1:0] fetch_pc,
    input logic          slot_nullify,
    input logic          rf_we,
    input logic          mem_we,
    input logic          seq_err,
    input logic [CW-1:0] branch_cnt,
    input logic [CW-1:0] squash_cnt
);
    logic chk_pred;
    always_comb chk_pred = hint_valid ? hint_taken : off_neg;

    p_plain_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> fetch_pc == $past(fetch_pc) + AW'(4));

    p_mismatch_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !seq_err && (br_taken != chk_pred)) |=> slot_nullify);

    p_match_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !seq_err && (br_taken == chk_pred)) |=> !slot_nullify);

    p_kill_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_nullify |-> (!rf_we && !mem_we));

    p_taken_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !seq_err && br_taken) |=> fetch_pc == $past(br_target));

    p_single_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_nullify |=> !slot_nullify);

    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> (!slot_nullify && branch_cnt == $past(branch_cnt)));

    p_squash_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        slot_nullify |-> squash_cnt == $past(squash_cnt) + CW'(1));
endmodule

bind cancel_slot_ctrl cancel_slot_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .br_valid     (br_valid),
    .hint_valid   (hint_valid),
    .hint_taken   (hint_taken),
    .off_neg      (off_neg),
    .br_taken     (br_taken),
    .br_target    (br_target),
    .fetch_pc     (fetch_pc),
    .slot_nullify (slot_nullify),
    .rf_we        (rf_we),
    .mem_we       (mem_we),
    .seq_err      (seq_err),
    .branch_cnt   (branch_cnt),
    .squash_cnt   (squash_cnt)
);

// File: tb/cancel_slot_ctrl_test.sv
module cancel_slot_ctrl_test;
    localparam int          AW    = 32;
    localparam int          CW    = 4;
    localparam logic [31:0] RST_A = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          br_valid, hint_valid, hint_taken, off_neg, br_taken;
    logic [AW-1:0] br_target;
    logic          dec_rf_we, dec_mem_we;
    logic [AW-1:0] fetch_pc, next_pc;
    logic          slot_nullify, rf_we, mem_we, seq_err;
    logic [CW-1:0] branch_cnt, squash_cnt;

    always #10 clk = ~clk;

    cancel_slot_ctrl #(.AW(AW), .CW(CW), .RESET_PC(RST_A)) uut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .hint_valid(hint_valid),
        .hint_taken(hint_taken), .off_neg(off_neg), .br_taken(br_taken),
        .br_target(br_target), .dec_rf_we(dec_rf_we), .dec_mem_we(dec_mem_we),
        .fetch_pc(fetch_pc), .next_pc(next_pc), .slot_nullify(slot_nullify),
        .rf_we(rf_we), .mem_we(mem_we), .seq_err(seq_err),
        .branch_cnt(branch_cnt), .squash_cnt(squash_cnt));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench model: 0 none pending, 1 slot kept, 2 slot killed
    int            m_pend = 0;
    logic [AW-1:0] m_pc   = RST_A;
    logic [CW-1:0] m_bcnt = '0;
    logic [CW-1:0] m_scnt = '0;

    function automatic logic f_pred(logic hv, logic ht, logic neg);
        return hv ? ht : neg;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // called at a falling edge; checks a quarter period later, ends at next falling edge
    task automatic step(logic bv, logic hv, logic ht, logic neg, logic tk,
                        logic [AW-1:0] tgt, logic rw, logic mw);
        logic          e_null, e_err, legal;
        logic [AW-1:0] e_next;
        br_valid = bv; hint_valid = hv; hint_taken = ht; off_neg = neg;
        br_taken = tk; br_target = tgt; dec_rf_we = rw; dec_mem_we = mw;
        #5;
        e_null = (m_pend == 2);
        e_err  = bv && (m_pend != 0);
        legal  = bv && (m_pend == 0);
        e_next = (legal && tk) ? tgt : m_pc + 32'd4;
        chk("R2", "fetch_pc", fetch_pc, m_pc);
        chk("R6", "next_pc", next_pc, e_next);
        chk(e_null ? "R5" : "R4", "slot_nullify", {31'd0, slot_nullify}, {31'd0, e_null});
        chk(e_null ? "R5" : "R4", "rf_we", {31'd0, rf_we}, {31'd0, rw & ~e_null});
        chk(e_null ? "R5" : "R4", "mem_we", {31'd0, mem_we}, {31'd0, mw & ~e_null});
        chk("R8", "seq_err", {31'd0, seq_err}, {31'd0, e_err});
        chk("R9", "branch_cnt", {28'd0, branch_cnt}, {28'd0, m_bcnt});
        chk("R10", "squash_cnt", {28'd0, squash_cnt}, {28'd0, m_scnt});
        m_pc = e_next;
        if (legal) begin
            m_bcnt = m_bcnt + 1'b1;
            if (tk != f_pred(hv, ht, neg)) begin
                m_pend = 2;
                m_scnt = m_scnt + 1'b1;
            end else begin
                m_pend = 1;
            end
        end else begin
            m_pend = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        br_valid = 0; hint_valid = 0; hint_taken = 0; off_neg = 0; br_taken = 0;
        br_target = '0; dec_rf_we = 0; dec_mem_we = 0;
        repeat (3) @(negedge clk);
        // R1: state while in reset
        chk("R1", "fetch_pc in reset", fetch_pc, RST_A);
        chk("R1", "slot_nullify in reset", {31'd0, slot_nullify}, 32'd0);
        chk("R1", "branch_cnt in reset", {28'd0, branch_cnt}, 32'd0);
        rst_n = 1'b1;
        // first cycle after reset (R1) and plain sequencing (R2)
        step(0, 0, 0, 0, 0, '0, 1, 1);
        step(0, 0, 0, 0, 0, '0, 1, 0);
        // R3/R4: hinted taken, taken -> slot kept, then slot with writes
        step(1, 1, 1, 0, 1, 32'h0000_2000, 1, 1);
        step(0, 0, 0, 0, 0, '0, 1, 1);
        // R5/R6: hinted taken, not taken -> fall through, slot killed
        step(1, 1, 1, 0, 0, 32'h0000_3000, 0, 0);
        step(0, 0, 0, 0, 0, '0, 1, 1);
        // R7: cycle after a killed slot
        step(0, 0, 0, 0, 0, '0, 1, 1);
        // R3: no hint, backward, taken -> match
        step(1, 0, 0, 1, 1, 32'h0000_0800, 0, 0);
        step(0, 0, 0, 0, 0, '0, 1, 1);
        // R3: no hint, forward, taken -> mismatch, redirect anyway (R6)
        step(1, 0, 1, 0, 1, 32'h0000_4400, 0, 0);
        step(0, 0, 0, 0, 0, '0, 1, 1);
        // R8: branch in a delay slot
        step(1, 1, 0, 0, 1, 32'h0000_5000, 0, 0);
        step(1, 1, 1, 1, 1, 32'h0000_6000, 1, 1);
        step(0, 0, 0, 0, 0, '0, 1, 1);
        // R8: branch in a killed slot
        step(1, 1, 0, 0, 1, 32'h0000_7000, 0, 0);
        step(1, 0, 0, 1, 1, 32'h0000_7800, 1, 1);
        step(0, 0, 0, 0, 0, '0, 0, 0);
        // random mix; CW=4 so R9 and R10 wrap
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step((r[3:0] < 4'd6), r[4], r[5], r[6], r[7],
                 {$urandom} & 32'hFFFF_FFFC, r[8], r[9]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule